// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This block runs the refill of one cache line after a miss so that the processor can resume before the whole line is in. When it accepts a miss, it issues a single burst request to memory. It then takes the returning words into a line buffer. The word the processor is waiting for is passed straight through to the processor in the cycle it arrives. A restart strobe in that cycle releases the processor, and the remaining words keep landing in the buffer.

There are two orderings, selected per miss. In critical-first order the burst begins at the missed word and wraps around the end of the line. In ascending order the burst begins at word 0, and the restart comes when the wanted word happens to arrive. While a fill is running, the processor may read other words of the line. A word that has already arrived, or that arrives in the same cycle, is served from the buffer. A word that has not arrived yet produces a stall.

The controller has five states:

- `ST_IDLE` waits for a miss. It moves to `ST_REQ` when a miss is accepted.
- `ST_REQ` issues the memory request for one cycle, then moves to `ST_FILL`.
- `ST_FILL` takes words until the missed word arrives. On that word it moves to `ST_DRAIN`, or straight to `ST_DONE` if that word is also the last of the burst.
- `ST_DRAIN` takes the remaining words. After the last one it moves to `ST_DONE`.
- `ST_DONE` pulses the completion strobe, marks the line valid and returns to `ST_IDLE`.

Top module: `cwf_fill_unit`

## Requirements
- R1: After reset, busy, line_valid, mem_req_valid, fill_done, cpu_valid and restart are all 0, and acc_stall is 1 for any access.
- R2: A miss_valid sampled in idle makes mem_req_valid high for exactly the next cycle. In that cycle mem_req_line equals the miss line and busy is high. mem_req_word equals miss_word when miss_order is 0 (critical-first), and equals 0 when miss_order is 1 (ascending).
- R3: In critical-first order, the k-th accepted memory word (k counted from 0) is written to word (miss_word + k) mod WORDS of the line.
- R4: In ascending order, the k-th accepted memory word is written to word k.
- R5: cpu_valid and restart are high, and cpu_data equals mem_rd_data, in exactly the cycle in which the word at index miss_word arrives. This happens exactly once per fill.
- R6: fill_done is a one-cycle pulse in the cycle after the WORDS-th word arrives, with busy still high. From the next cycle line_valid is 1 and busy is 0. line_valid stays 1 until the next miss is accepted.
- R7: miss_valid while busy is ignored: no new request is issued and the running fill keeps its original line, start word and order.
- R8: mem_rd_valid while idle is ignored: line_data is unchanged and cpu_valid stays 0.
- R9: An access (acc_valid, acc_word) gives acc_hit with acc_data equal to the stored word if that word has arrived in the current fill. It also gives acc_hit if the word arrives in the same cycle, and then acc_data equals mem_rd_data. Otherwise it gives acc_stall. acc_hit and acc_stall are never both high.
- R10: After fill_done, line_data holds every word of the line at its own index, with word i in bits [i*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | OFF_W | Word offset that missed |
| miss_order | input | 1 | 0 critical-first, 1 ascending |
| busy | output | 1 | High for the whole fill |
| mem_req_valid | output | 1 | One-cycle burst request |
| mem_req_line | output | LINE_W | Requested line address |
| mem_req_word | output | OFF_W | First word of the burst |
| mem_rd_valid | input | 1 | Memory word strobe |
| mem_rd_data | input | DATA_W | Memory word |
| cpu_valid | output | 1 | Missed word delivered |
| cpu_data | output | DATA_W | Missed word data |
| restart | output | 1 | Processor release strobe |
| acc_valid | input | 1 | Access to the line being filled |
| acc_word | input | OFF_W | Word index of the access |
| acc_hit | output | 1 | Access served |
| acc_stall | output | 1 | Access must wait |
| acc_data | output | DATA_W | Served data |
| fill_done | output | 1 | Fill complete pulse |
| line_valid | output | 1 | Line buffer holds a complete line |
| line_data | output | WORDS*DATA_W | Line buffer contents |

## Verification
The bench builds the block with its defaults: 8 words per line, 32-bit words and 26-bit line addresses. Because the line is short, both orderings can be run from every start word. This covers a burst that needs no wrap (start 0), one that wraps after the first word (start 7), and one where the wanted word is the last of an ascending burst, so that restart and completion fall one cycle apart. Random gaps in the memory stream, random accesses during the fill and misses thrown at a busy unit put arrival-cycle forwarding, stalls and the ignored-request paths in reach.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FILL,
        ST_DRAIN,
        ST_DONE
    } fill_state_e;

    typedef enum logic {
        ORD_CRIT = 1'b0,
        ORD_ASC  = 1'b1
    } fill_order_e;
endpackage

// File: rtl/cwf_order_gen.sv
module cwf_order_gen #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] start_in,
    input  logic             advance,
    output logic [OFF_W-1:0] idx,
    output logic             last
);
    localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(WORDS - 1);
    localparam logic [OFF_W:0]   WRAP     = (OFF_W+1)'(WORDS);

    logic [OFF_W-1:0] start_q;
    logic [OFF_W-1:0] cnt_q;
    logic [OFF_W:0]   sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            start_q <= start_in;
            cnt_q   <= '0;
        end else if (advance) begin
            cnt_q   <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        sum = {1'b0, start_q} + {1'b0, cnt_q};
        if (sum >= WRAP) begin
            sum = sum - WRAP;
        end
        idx  = sum[OFF_W-1:0];
        last = (cnt_q == LAST_CNT);
    end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic [OFF_W-1:0]        rd_idx,
    output logic                    rd_hit,
    output logic                    rd_stall,
    output logic [DATA_W-1:0]       rd_data,
    output logic [WORDS*DATA_W-1:0] line_flat
);
    logic [DATA_W-1:0] store_q [WORDS];
    logic [WORDS-1:0]  have_q;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q[g] <= '0;
                have_q[g]  <= 1'b0;
            end else if (clear) begin
                have_q[g]  <= 1'b0;
            end else if (wr_en && wr_idx == OFF_W'(g)) begin
                store_q[g] <= wr_data;
                have_q[g]  <= 1'b1;
            end
        end
        assign line_flat[g*DATA_W +: DATA_W] = store_q[g];
    end

    always_comb begin
        rd_hit   = 1'b0;
        rd_stall = 1'b0;
        rd_data  = '0;
        if (rd_en) begin
            if (have_q[rd_idx]) begin
                rd_hit  = 1'b1;
                rd_data = store_q[rd_idx];
            end else if (wr_en && wr_idx == rd_idx) begin
                rd_hit  = 1'b1;
                rd_data = wr_data;
            end else begin
                rd_stall = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cwf_fill_unit.sv
module cwf_fill_unit
    import cwf_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int LINE_W = 26,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    input  logic [LINE_W-1:0]       miss_line,
    input  logic [OFF_W-1:0]        miss_word,
    input  logic                    miss_order,
    output logic                    busy,
    output logic                    mem_req_valid,
    output logic [LINE_W-1:0]       mem_req_line,
    output logic [OFF_W-1:0]        mem_req_word,
    input  logic                    mem_rd_valid,
    input  logic [DATA_W-1:0]       mem_rd_data,
    output logic                    cpu_valid,
    output logic [DATA_W-1:0]       cpu_data,
    output logic                    restart,
    input  logic                    acc_valid,
    input  logic [OFF_W-1:0]        acc_word,
    output logic                    acc_hit,
    output logic                    acc_stall,
    output logic [DATA_W-1:0]       acc_data,
    output logic                    fill_done,
    output logic                    line_valid,
    output logic [WORDS*DATA_W-1:0] line_data
);
    fill_state_e      state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  crit_q;
    logic [OFF_W-1:0]  start_sel;
    logic              line_valid_q;
    logic              accept;
    logic              word_in;
    logic              crit_now;
    logic [OFF_W-1:0]  cur_idx;
    logic              cur_last;

    assign accept    = (state_q == ST_IDLE) && miss_valid;
    assign start_sel = (fill_order_e'(miss_order) == ORD_ASC) ? '0 : miss_word;
    assign word_in   = mem_rd_valid && (state_q == ST_FILL || state_q == ST_DRAIN);
    assign crit_now  = word_in && (state_q == ST_FILL) && (cur_idx == crit_q);

    cwf_order_gen #(.WORDS(WORDS)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .start_in (start_sel),
        .advance  (word_in),
        .idx      (cur_idx),
        .last     (cur_last)
    );

    cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .wr_en     (word_in),
        .wr_idx    (cur_idx),
        .wr_data   (mem_rd_data),
        .rd_en     (acc_valid),
        .rd_idx    (acc_word),
        .rd_hit    (acc_hit),
        .rd_stall  (acc_stall),
        .rd_data   (acc_data),
        .line_flat (line_data)
    );

    // State register and per-fill context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            line_q       <= '0;
            crit_q       <= '0;
            line_valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                line_q       <= miss_line;
                crit_q       <= miss_word;
                line_valid_q <= 1'b0;
            end else if (state_q == ST_DONE) begin
                line_valid_q <= 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid) state_d = ST_REQ;
            ST_REQ:   state_d = ST_FILL;
            ST_FILL: begin
                if (word_in && cur_last)  state_d = ST_DONE;
                else if (crit_now)        state_d = ST_DRAIN;
            end
            ST_DRAIN: if (word_in && cur_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy          = 1'b0;
        mem_req_valid = 1'b0;
        fill_done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_REQ: begin
                busy          = 1'b1;
                mem_req_valid = 1'b1;
            end
            ST_FILL:  busy = 1'b1;
            ST_DRAIN: busy = 1'b1;
            ST_DONE: begin
                busy      = 1'b1;
                fill_done = 1'b1;
            end
            default:  busy = 1'b0;
        endcase
    end

    assign mem_req_line = line_q;
    assign mem_req_word = u_order.start_q;
    assign cpu_valid    = crit_now;
    assign restart      = crit_now;
    assign cpu_data     = crit_now ? mem_rd_data : '0;
    assign line_valid   = line_valid_q;
endmodule

// File: rtl/cwf_fill_chk.sv
module cwf_fill_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic mem_req_valid,
    input logic fill_done,
    input logic line_valid,
    input logic restart,
    input logic cpu_valid,
    input logic acc_hit,
    input logic acc_stall
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cpu_valid && !fill_done && !mem_req_valid));

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> (!mem_req_valid && busy));

    // R7
    req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !$past(busy));

    // R5
    restart_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (cpu_valid && busy));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (!fill_done && line_valid && !busy));

    // R9
    acc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_hit && acc_stall));
endmodule

bind cwf_fill_unit cwf_fill_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .fill_done     (fill_done),
    .line_valid    (line_valid),
    .restart       (restart),
    .cpu_valid     (cpu_valid),
    .acc_hit       (acc_hit),
    .acc_stall     (acc_stall)
);

// File: tb/cwf_fill_unit_test.sv
module cwf_fill_unit_test;
    localparam int WORDS  = 8;
    localparam int DATA_W = 32;
    localparam int LINE_W = 26;
    localparam int OFF_W  = $clog2(WORDS);
    localparam time CLK_PERIOD = 10ns;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    miss_valid = 1'b0;
    logic [LINE_W-1:0]       miss_line = '0;
    logic [OFF_W-1:0]        miss_word = '0;
    logic                    miss_order = 1'b0;
    logic                    busy;
    logic                    mem_req_valid;
    logic [LINE_W-1:0]       mem_req_line;
    logic [OFF_W-1:0]        mem_req_word;
    logic                    mem_rd_valid = 1'b0;
    logic [DATA_W-1:0]       mem_rd_data = '0;
    logic                    cpu_valid;
    logic [DATA_W-1:0]       cpu_data;
    logic                    restart;
    logic                    acc_valid = 1'b0;
    logic [OFF_W-1:0]        acc_word = '0;
    logic                    acc_hit;
    logic                    acc_stall;
    logic [DATA_W-1:0]       acc_data;
    logic                    fill_done;
    logic                    line_valid;
    logic [WORDS*DATA_W-1:0] line_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwf_fill_unit #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) uut (.*);

    function automatic logic [DATA_W-1:0] mem_word(logic [LINE_W-1:0] ln, int i);
        return (32'h5A00_0000 ^ (32'(ln) * 32'd97)) + 32'(i) * 32'h0101_0103 + 32'd1;
    endfunction

    function automatic int exp_idx(int start, int k);
        return (start + k) % WORDS;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check_line(logic [LINE_W-1:0] ln, string req);
        for (int i = 0; i < WORDS; i++) begin
            chk(line_data[i*DATA_W +: DATA_W] == mem_word(ln, i), req,
                line_data[i*DATA_W +: DATA_W], mem_word(ln, i));
        end
    endtask

    // One fill: ord 0 critical-first, 1 ascending
    task automatic do_fill(logic [LINE_W-1:0] ln, int word, bit ord, bit noisy);
        int start;
        int restarts;
        logic [WORDS-1:0] have;
        start    = ord ? 0 : word;
        restarts = 0;
        have     = '0;
        @(negedge clk);
        miss_valid = 1'b1; miss_line = ln; miss_word = OFF_W'(word); miss_order = ord;
        @(negedge clk);
        // R2 request cycle
        chk(mem_req_valid == 1'b1, "R2 req", 64'(mem_req_valid), 1);
        chk(mem_req_line == ln, "R2 line", 64'(mem_req_line), 64'(ln));
        chk(mem_req_word == OFF_W'(start), "R2 word", 64'(mem_req_word), 64'(start));
        chk(busy == 1'b1, "R2 busy", 64'(busy), 1);
        chk(line_valid == 1'b0, "R6 cleared", 64'(line_valid), 0);
        miss_valid = 1'b0;
        for (int k = 0; k < WORDS; k++) begin
            int idx;
            idx = exp_idx(start, k);
            while (($urandom % 3) == 0) begin
                @(negedge clk);
                chk(mem_req_valid == 1'b0, "R7 no req", 64'(mem_req_valid), 0);
                mem_rd_valid = 1'b0;
                miss_valid = noisy ? 1'($urandom) : 1'b0;
                miss_line  = LINE_W'($urandom);
                miss_word  = OFF_W'($urandom);
                miss_order = 1'($urandom);
                acc_valid  = 1'($urandom);
                acc_word   = OFF_W'($urandom);
                #1;
                chk(cpu_valid == 1'b0, "R5 gap", 64'(cpu_valid), 0);
                if (acc_valid) begin
                    chk(acc_hit == have[acc_word], "R9 gap hit", 64'(acc_hit), 64'(have[acc_word]));
                    chk(acc_stall == !have[acc_word], "R9 gap stall", 64'(acc_stall), 64'(!have[acc_word]));
                    if (have[acc_word])
                        chk(acc_data == mem_word(ln, int'(acc_word)), "R9 gap data",
                            64'(acc_data), 64'(mem_word(ln, int'(acc_word))));
                end
            end
            @(negedge clk);
            chk(mem_req_valid == 1'b0, "R7 no req", 64'(mem_req_valid), 0);
            chk(busy == 1'b1, "R2 busy hold", 64'(busy), 1);
            miss_valid   = noisy ? 1'($urandom) : 1'b0;
            miss_line    = LINE_W'($urandom);
            miss_word    = OFF_W'($urandom);
            miss_order   = 1'($urandom);
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem_word(ln, idx);
            acc_valid    = 1'($urandom);
            acc_word     = OFF_W'($urandom);
            #1;
            chk(cpu_valid == (idx == word), ord ? "R5 R4 cpu_valid" : "R5 R3 cpu_valid",
                64'(cpu_valid), 64'(idx == word));
            chk(restart == (idx == word), "R5 restart", 64'(restart), 64'(idx == word));
            if (idx == word) begin
                restarts++;
                chk(cpu_data == mem_word(ln, idx), "R5 cpu_data", 64'(cpu_data), 64'(mem_word(ln, idx)));
            end
            if (acc_valid) begin
                bit e;
                e = have[acc_word] || (int'(acc_word) == idx);
                chk(acc_hit == e, "R9 hit", 64'(acc_hit), 64'(e));
                chk(acc_stall == !e, "R9 stall", 64'(acc_stall), 64'(!e));
                if (e)
                    chk(acc_data == mem_word(ln, int'(acc_word)), "R9 data",
                        64'(acc_data), 64'(mem_word(ln, int'(acc_word))));
            end
            have[idx] = 1'b1;
        end
        @(negedge clk);
        mem_rd_valid = 1'b0; acc_valid = 1'b0;
        chk(fill_done == 1'b1, "R6 done", 64'(fill_done), 1);
        chk(busy == 1'b1, "R6 busy at done", 64'(busy), 1);
        chk(mem_req_valid == 1'b0, "R7 no req", 64'(mem_req_valid), 0);
        chk(restarts == 1, "R5 once", 64'(restarts), 1);
        miss_valid = 1'b0;
        @(negedge clk);
        chk(fill_done == 1'b0, "R6 pulse", 64'(fill_done), 0);
        chk(line_valid == 1'b1, "R6 valid", 64'(line_valid), 1);
        chk(busy == 1'b0, "R6 idle", 64'(busy), 0);
        check_line(ln, ord ? "R10 R4 line" : "R10 R3 line");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [LINE_W-1:0] last_ln;
        void'($urandom(32'd1234));
        #1;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
        chk(line_valid == 1'b0, "R1 line_valid", 64'(line_valid), 0);
        chk(mem_req_valid == 1'b0, "R1 req", 64'(mem_req_valid), 0);
        chk(fill_done == 1'b0, "R1 done", 64'(fill_done), 0);
        chk(cpu_valid == 1'b0 && restart == 1'b0, "R1 cpu", 64'(cpu_valid), 0);
        acc_valid = 1'b1; acc_word = 3'd2; #1;
        chk(acc_stall == 1'b1 && acc_hit == 1'b0, "R1 acc", 64'(acc_stall), 1);
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        do_fill(26'h00_1234, 0, 1'b0, 1'b0);
        do_fill(26'h01_0F0F, 7, 1'b0, 1'b1);
        do_fill(26'h02_AAAA, 7, 1'b1, 1'b0);
        do_fill(26'h03_5555, 0, 1'b1, 1'b1);
        do_fill(26'h04_0001, 3, 1'b0, 1'b1);

        // Random fills
        last_ln = '0;
        for (int n = 0; n < 24; n++) begin
            last_ln = LINE_W'($urandom);
            do_fill(last_ln, int'($urandom % WORDS), 1'($urandom), 1'($urandom));
        end

        // R8 idle words ignored, R9 idle access after completion
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mem_rd_valid = 1'b1; mem_rd_data = $urandom;
            acc_valid = 1'b1; acc_word = OFF_W'(i);
            #1;
            chk(cpu_valid == 1'b0, "R8 cpu", 64'(cpu_valid), 0);
            chk(acc_hit == 1'b1, "R9 idle hit", 64'(acc_hit), 1);
            chk(acc_data == mem_word(last_ln, i), "R9 idle data", 64'(acc_data), 64'(mem_word(last_ln, i)));
        end
        @(negedge clk);
        mem_rd_valid = 1'b0; acc_valid = 1'b0;
        chk(busy == 1'b0, "R8 idle", 64'(busy), 0);
        check_line(last_ln, "R8 line kept");
        chk(line_valid == 1'b1, "R6 held", 64'(line_valid), 1);
        finish_run();
    end
endmodule